// File: doc/BRIEF.md
# Clock-Monitor Sticky Status and Interrupt Register

This block is the read-only status word of a clock-monitoring device. Each cycle it samples one fault flag per monitored input clock, a PLL lock indicator and the code of the currently selected input. Fault flags are latched, so a short fault stays visible until a configuration register sends an explicit clear strobe. Lock and select are not latched; they show the value sampled at the last clock edge.

An interrupt flag in the same word records events that software should look at. A fault bit going from 0 to 1 sets it, and so does losing lock or any change of the select code. Reading the word clears the flag. If an event arrives in the same cycle as the read, the event wins and the flag stays set. The flag drives an active-low interrupt pin only while a separate enable bit is 1.

Synchronous reset clears the fault bits and the flag. It also loads the lock and select history from the live inputs, so the first cycle after reset raises no interrupt.

Top module: `clkmon_status_reg`

## Requirements
- R1: With the default parameters the status word `rdata` is laid out as: bit 7 the interrupt flag, bits 6:3 the latched faults of clocks 3 down to 0 (bit 3+i for clock i), bit 2 the lock bit, and bits 1:0 the select code.
- R2: A fault bit becomes 1 on the clock edge at which its `flt_in` input is 1. It then stays 1 after the input returns to 0.
- R3: The fault bits are cleared to 0 at an edge where `clr_stb` is 1, even if a fault input is 1 in that cycle. If that fault input is still 1 at the next edge, its bit sets again.
- R4: The interrupt flag is set at any edge where a fault bit goes from 0 to 1, and this includes a re-set after a clear.
- R5: The interrupt flag is set at an edge where the lock bit goes from 1 to 0. A lock bit going from 0 to 1 does not set it.
- R6: The interrupt flag is set at any edge where the select code changes value.
- R7: A 1 on `rd_stb` clears the interrupt flag at the next edge, unless an R4–R6 event happens at that same edge, in which case the flag stays 1.
- R8: `irq_n` is 0 exactly when the interrupt flag is 1 and `int_en` is 1. Otherwise it is 1.
- R9: While `rst_n` is 0, each edge clears the faults and the interrupt flag and loads the lock and select bits from their inputs. The first edge after reset sets no interrupt when the inputs are unchanged.
- R10: The lock and select bits follow their inputs with a one-edge delay, in both directions, without latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flt_in | input | CLK_N (4) | Per-clock fault flags, active high |
| lock_in | input | 1 | PLL lock indicator, 1 = locked |
| sel_in | input | SEL_W (2) | Code of the active input clock |
| rd_stb | input | 1 | One-cycle pulse marking a read of the status word |
| clr_stb | input | 1 | Clear strobe for the latched fault bits |
| int_en | input | 1 | Interrupt pin enable |
| rdata | output | CLK_N+SEL_W+2 (8) | Status word |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
Directed sequences drive each event source on its own and then combine them:
- a single short fault pulse,
- a clear while the fault is still present,
- a read that coincides with a loss of lock,
- a regain of lock,
- a change of select code.

These separate a latch that merely copies its input from one that holds it. They also separate edge detection on the latched bit from detection on the raw input, and show whether a clearing read loses an event that arrives with it. A long random phase then mixes faults, lock toggles, select changes, reads, clears and enable changes in arbitrary overlap. A cycle-level model predicts the whole word and the pin for every cycle.

// File: rtl/clkmon_stat_pkg.sv
package clkmon_stat_pkg;

    localparam int CLK_N_DEF = 4;
    localparam int SEL_W_DEF = 2;

    // Sources able to raise the interrupt flag
    typedef struct packed {
        logic flt_rise;
        logic lock_drop;
        logic sel_chg;
    } irq_src_t;

endpackage

// File: rtl/clkmon_sticky_bank.sv
module clkmon_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flt_in,
    input  logic         clr_stb,
    output logic [N-1:0] sticky_q,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        typedef struct packed {
            logic hold;
        } bit_st_t;

        bit_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (!rst_n) begin
                st_d.hold = 1'b0;
            end else if (clr_stb) begin
                st_d.hold = 1'b0;
            end else begin
                st_d.hold = st_q.hold | flt_in[i];
            end
            rise[i] = st_d.hold & ~st_q.hold & rst_n;
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign sticky_q[i] = st_q.hold;
    end

endmodule

// File: rtl/clkmon_change_det.sv
module clkmon_change_det #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_in,
    input  logic [SEL_W-1:0] sel_in,
    output logic             lock_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             lock_drop,
    output logic             sel_chg
);

    typedef struct packed {
        logic             lock;
        logic [SEL_W-1:0] sel;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d.lock  = lock_in;
        h_d.sel   = sel_in;
        lock_drop = rst_n & h_q.lock & ~lock_in;
        sel_chg   = rst_n & (h_q.sel != sel_in);
    end

    always_ff @(posedge clk) begin
        h_q <= h_d;
    end

    assign lock_q = h_q.lock;
    assign sel_q  = h_q.sel;

endmodule

// File: rtl/clkmon_status_reg.sv
module clkmon_status_reg
    import clkmon_stat_pkg::*;
#(
    parameter int CLK_N = CLK_N_DEF,
    parameter int SEL_W = SEL_W_DEF,
    localparam int RW   = CLK_N + SEL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLK_N-1:0] flt_in,
    input  logic             lock_in,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             rd_stb,
    input  logic             clr_stb,
    input  logic             int_en,
    output logic [RW-1:0]    rdata,
    output logic             irq_n
);

    typedef struct packed {
        logic flag;
    } irq_st_t;

    logic [CLK_N-1:0] sticky;
    logic [CLK_N-1:0] rise;
    logic             lock_q;
    logic [SEL_W-1:0] sel_q;
    logic             lock_drop;
    logic             sel_chg;
    irq_src_t         src;
    irq_st_t          irq_d, irq_q;

    clkmon_sticky_bank #(.N(CLK_N)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .flt_in   (flt_in),
        .clr_stb  (clr_stb),
        .sticky_q (sticky),
        .rise     (rise)
    );

    clkmon_change_det #(.SEL_W(SEL_W)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_in   (lock_in),
        .sel_in    (sel_in),
        .lock_q    (lock_q),
        .sel_q     (sel_q),
        .lock_drop (lock_drop),
        .sel_chg   (sel_chg)
    );

    always_comb begin
        src.flt_rise  = |rise;
        src.lock_drop = lock_drop;
        src.sel_chg   = sel_chg;
        irq_d         = irq_q;
        if (!rst_n) begin
            irq_d.flag = 1'b0;
        end else begin
            // a new event outranks a clearing read
            irq_d.flag = (|src) | (irq_q.flag & ~rd_stb);
        end
    end

    always_ff @(posedge clk) begin
        irq_q <= irq_d;
    end

    assign rdata = {irq_q.flag, sticky, lock_q, sel_q};
    assign irq_n = ~(irq_q.flag & int_en);

endmodule

// File: rtl/clkmon_status_chk.sv
module clkmon_status_chk #(
    parameter int CLK_N = 4,
    parameter int SEL_W = 2,
    localparam int RW   = CLK_N + SEL_W + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_stb,
    input logic          clr_stb,
    input logic          int_en,
    input logic [RW-1:0] rdata,
    input logic          irq_n
);

    localparam int IB = RW - 1;
    localparam int LB = SEL_W;

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    wire warm = warm_q >= 2'd2;

    wire [CLK_N-1:0] stat = rdata[RW-2:SEL_W+1];
    wire [SEL_W-1:0] sel  = rdata[SEL_W-1:0];

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        warm && !$past(clr_stb) |-> ((stat & $past(stat)) == $past(stat))); // R2
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(clr_stb) |-> (stat == '0)); // R3
    AST_RISE_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        warm && ((stat & ~$past(stat)) != '0) |-> rdata[IB]); // R4
    AST_LOCK_DROP_INT: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $fell(rdata[LB]) |-> rdata[IB]); // R5
    AST_SEL_CHG_INT: assert property (@(posedge clk) disable iff (!rst_n)
        warm && (sel != $past(sel)) |-> rdata[IB]); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        warm && $past(rd_stb) && rdata[IB] |->
        (((stat & ~$past(stat)) != '0) || $fell(rdata[LB]) || (sel != $past(sel)))); // R7
    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> irq_n); // R8

endmodule

bind clkmon_status_reg clkmon_status_chk #(.CLK_N(CLK_N), .SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .clr_stb (clr_stb),
    .int_en  (int_en),
    .rdata   (rdata),
    .irq_n   (irq_n)
);

// File: tb/clkmon_status_reg_bench.sv
`timescale 1ns/1ps
module clkmon_status_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] flt_in = '0;
    logic       lock_in = 1'b1;
    logic [1:0] sel_in = 2'd2;
    logic       rd_stb = 1'b0;
    logic       clr_stb = 1'b0;
    logic       int_en = 1'b0;
    logic [7:0] rdata;
    logic       irq_n;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit [3:0] m_flt;
    bit       m_int, m_lock;
    bit [1:0] m_sel;

    always #2.5 clk = ~clk;

    clkmon_status_reg u_clkmon_status_reg (
        .clk(clk), .rst_n(rst_n), .flt_in(flt_in), .lock_in(lock_in),
        .sel_in(sel_in), .rd_stb(rd_stb), .clr_stb(clr_stb),
        .int_en(int_en), .rdata(rdata), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        bit ev;
        cycles++;
        if (!rst_n) begin
            m_flt = '0; m_int = 0; m_lock = lock_in; m_sel = sel_in;
        end else begin
            ev = 0;
            for (int i = 0; i < 4; i++) begin
                bit nb;
                nb = clr_stb ? 1'b0 : (m_flt[i] | flt_in[i]);
                if (nb && !m_flt[i]) ev = 1;
                m_flt[i] = nb;
            end
            if (m_lock && !lock_in) ev = 1;
            if (m_sel != sel_in) ev = 1;
            m_lock = lock_in;
            m_sel  = sel_in;
            m_int  = ev || (m_int && !rd_stb);
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk({7'd0, rdata[7]},   {7'd0, m_int},  "R1/R4/R5/R6/R7 model INT bit");
        chk({4'd0, rdata[6:3]}, {4'd0, m_flt},  "R2/R3 model fault field");
        chk({5'd0, rdata[2:0]}, {5'd0, m_lock, m_sel}, "R10 model lock/select");
        chk({7'd0, irq_n}, {7'd0, !(m_int && int_en)}, "R8 model pin");
    endtask

    initial begin
        cyc();
        chk(rdata, 8'h06, "R9 reset loads lock/select");
        chk({7'd0, irq_n}, 8'd1, "R9 pin idle in reset");
        rst_n = 1'b1;
        cyc();
        chk({7'd0, rdata[7]}, 8'd0, "R9 no event after reset");
        flt_in = 4'b0100;
        cyc();
        chk(rdata, 8'hA6, "R2 R4 fault latched and INT set");
        chk({7'd0, irq_n}, 8'd1, "R8 pin masked when disabled");
        flt_in = 4'b0000; int_en = 1'b1;
        cyc();
        chk({4'd0, rdata[6:3]}, 8'h04, "R2 fault held after input drops");
        chk({7'd0, irq_n}, 8'd0, "R8 pin asserted when enabled");
        rd_stb = 1'b1;
        cyc();
        rd_stb = 1'b0;
        chk({7'd0, rdata[7]}, 8'd0, "R7 read clears INT");
        flt_in = 4'b0100; clr_stb = 1'b1;
        cyc();
        chk(rdata, 8'h06, "R3 clear beats present fault");
        clr_stb = 1'b0;
        cyc();
        chk(rdata, 8'hA6, "R3 R4 fault re-set raises INT");
        flt_in = 4'b0000; rd_stb = 1'b1;
        cyc();
        lock_in = 1'b0;
        cyc();
        chk({7'd0, rdata[7]}, 8'd1, "R5 R7 lock loss beats read");
        chk({7'd0, rdata[2]}, 8'd0, "R10 lock follows low");
        cyc();
        rd_stb = 1'b0;
        chk({7'd0, rdata[7]}, 8'd0, "R7 read clears after event");
        lock_in = 1'b1;
        cyc();
        chk({7'd0, rdata[7]}, 8'd0, "R5 lock gain raises nothing");
        chk({7'd0, rdata[2]}, 8'd1, "R10 lock follows high");
        sel_in = 2'd1;
        cyc();
        chk({6'd0, rdata[7], rdata[0]}, 8'd3, "R6 select change sets INT");
        chk({6'd0, rdata[1:0]}, 8'd1, "R1 select field bits 1:0");
        for (int n = 0; n < 3000; n++) begin
            flt_in  = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd0;
            lock_in = ($urandom_range(0, 9) == 0) ? ~lock_in : lock_in;
            sel_in  = ($urandom_range(0, 11) == 0) ? 2'($urandom) : sel_in;
            rd_stb  = ($urandom_range(0, 3) == 0);
            clr_stb = ($urandom_range(0, 9) == 0);
            int_en  = ($urandom_range(0, 7) != 0);
            rst_n   = ($urandom_range(0, 499) != 0);
            cyc();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule